// File: doc/BRIEF.md
# Byte/Word Lane Controller for a 16-bit Memory Bus

This block sits between a requester and a 16-bit wide memory built from two byte-wide halves. Each request carries a byte address, a write flag, a size flag and 16 bits of write data. The block turns it into memory-side signals: a halfword address (byte address with bit 0 dropped), an active-low read strobe, two active-low write strobes (one per byte lane), and write data placed on the correct lane. The byte at an even address lives on the upper lane (bits 15..8) and the byte at the following odd address lives on the lower lane (bits 7..0).

Reads always move a full 16-bit word across the bus. For a byte read, the block keeps the addressed byte and drops the other one. A 16-bit access at an odd address would need two different halfword addresses at once, so it is refused with an error pulse and never reaches the memory.

Each accepted request drives its strobes low for exactly one clock and then raises a done pulse. The block then accepts the next request in the done cycle, so requests can be issued every second clock.

Top module: `membus_lane_ctrl`

## Requirements
- R1: While and after synchronous reset, with no request, mem_rd_n, mem_wrh_n and mem_wrl_n are 1, rsp_done and rsp_err are 0 and rsp_rdata is 0.
- R2: A request accepted at a clock edge (req_valid=1, block idle, not misaligned) drives its strobes low for exactly the next clock cycle, with mem_addr equal to req_addr[ADDR_W-1:1] in that cycle.
- R3: A byte write (req_write=1, req_word=0) at an even address (req_addr[0]=0) pulls only mem_wrh_n low and places req_wdata[7:0] on mem_wdata[15:8].
- R4: A byte write at an odd address (req_addr[0]=1) pulls only mem_wrl_n low and places req_wdata[7:0] on mem_wdata[7:0].
- R5: A word write (req_write=1, req_word=1) at an even address pulls mem_wrh_n and mem_wrl_n low in the same cycle and drives mem_wdata equal to req_wdata.
- R6: A read (req_write=0) pulls only mem_rd_n low; for a word read rsp_rdata equals the mem_rdata value present in the strobe cycle.
- R7: For a byte read, rsp_rdata is {8'h00, mem_rdata[15:8]} at an even address and {8'h00, mem_rdata[7:0]} at an odd address, using mem_rdata from the strobe cycle.
- R8: rsp_done is high for exactly the one cycle after the strobe cycle, and rsp_rdata holds the read result from that cycle on.
- R9: A word request (read or write) at an odd address raises rsp_err for exactly the next cycle, drives no strobe and produces no rsp_done.
- R10: A request presented while a strobe cycle is in progress is ignored: in the following cycle all strobes are high and mem_addr is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 2*LANE_W | Write data; byte writes use bits 7..0 |
| mem_addr | output | ADDR_W-1 | Halfword address to memory |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wrh_n | output | 1 | Active-low write strobe, upper lane (even byte) |
| mem_wrl_n | output | 1 | Active-low write strobe, lower lane (odd byte) |
| mem_wdata | output | 2*LANE_W | Lane-steered write data |
| mem_rdata | input | 2*LANE_W | Word returned by memory |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle misaligned-request pulse |
| rsp_rdata | output | 2*LANE_W | Aligned read result |

## Verification
The assertions take for granted that the request fields are known (no X) whenever reset is low, and that the fields seen at the accepting edge are the ones the lane properties trace back through one cycle of history; they place no constraint on how often req_valid is raised. The stimulus drives every input from the bench at the falling edge, always with defined values, and mixes random addresses, sizes and directions with deliberate misaligned word requests and requests issued during a strobe cycle. It supplies mem_rdata fresh in each strobe cycle so each read result can only come from that cycle's bus value.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic {ST_IDLE, ST_STROBE} seq_state_t;

  // active-high strobe enables, inverted at the pins
  typedef struct packed {
    logic rd;
    logic wrh;
    logic wrl;
  } strobe_t;
endpackage

// File: rtl/membus_lane_steer.sv
module membus_lane_steer
  import membus_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                  addr0,
  input  logic                  write,
  input  logic                  word,
  input  logic [2*LANE_W-1:0]   wdata,
  output strobe_t               en,
  output logic                  misaligned,
  output logic [2*LANE_W-1:0]   wdata_lane
);
  localparam int DATA_W = 2 * LANE_W;

  logic [DATA_W-1:0] byte_dup;

  // a byte write copies its byte to both lanes; only one strobe fires
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_dup
      assign byte_dup[g*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
    end
  endgenerate

  always_comb begin
    misaligned = word & addr0;
    en.rd      = ~write;
    en.wrh     = write & (word | ~addr0);
    en.wrl     = write & (word | addr0);
    wdata_lane = word ? wdata : byte_dup;
  end
endmodule

// File: rtl/membus_read_align.sv
module membus_read_align #(
  parameter int LANE_W = 8
) (
  input  logic                  word,
  input  logic                  addr0,
  input  logic [2*LANE_W-1:0]   bus,
  output logic [2*LANE_W-1:0]   data
);
  localparam int DATA_W = 2 * LANE_W;

  logic [LANE_W-1:0] sel;

  always_comb begin
    sel  = addr0 ? bus[LANE_W-1:0] : bus[DATA_W-1:LANE_W];
    data = word ? bus : {{LANE_W{1'b0}}, sel};
  end
endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    misaligned,
  input  strobe_t req_en,
  output logic    accept,
  output strobe_t act_q,
  output logic    done_q,
  output logic    err_q,
  output logic    capture
);
  seq_state_t state_q;
  logic       idle;

  always_comb begin
    idle    = (state_q == ST_IDLE);
    accept  = req_valid & idle & ~misaligned;
    capture = (state_q == ST_STROBE) & act_q.rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= (state_q == ST_STROBE);
      err_q  <= req_valid & idle & misaligned;
      if (accept) begin
        state_q <= ST_STROBE;
        act_q   <= req_en;
      end else begin
        state_q <= ST_IDLE;
        act_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/membus_lane_ctrl.sv
module membus_lane_ctrl
  import membus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic                  req_word,
  input  logic [2*LANE_W-1:0]   req_wdata,
  output logic [ADDR_W-2:0]     mem_addr,
  output logic                  mem_rd_n,
  output logic                  mem_wrh_n,
  output logic                  mem_wrl_n,
  output logic [2*LANE_W-1:0]   mem_wdata,
  input  logic [2*LANE_W-1:0]   mem_rdata,
  output logic                  rsp_done,
  output logic                  rsp_err,
  output logic [2*LANE_W-1:0]   rsp_rdata
);
  localparam int DATA_W = 2 * LANE_W;

  strobe_t           req_en;
  strobe_t           act_q;
  logic              misaligned;
  logic              accept;
  logic              capture;
  logic              done_q;
  logic              err_q;
  logic [DATA_W-1:0] wdata_lane;
  logic [DATA_W-1:0] rd_aligned;
  logic [ADDR_W-2:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              word_q;
  logic              a0_q;

  membus_lane_steer #(.LANE_W(LANE_W)) i_steer (
    .addr0      (req_addr[0]),
    .write      (req_write),
    .word       (req_word),
    .wdata      (req_wdata),
    .en         (req_en),
    .misaligned (misaligned),
    .wdata_lane (wdata_lane)
  );

  membus_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .misaligned (misaligned),
    .req_en     (req_en),
    .accept     (accept),
    .act_q      (act_q),
    .done_q     (done_q),
    .err_q      (err_q),
    .capture    (capture)
  );

  membus_read_align #(.LANE_W(LANE_W)) i_align (
    .word  (word_q),
    .addr0 (a0_q),
    .bus   (mem_rdata),
    .data  (rd_aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      word_q  <= 1'b0;
      a0_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr[ADDR_W-1:1];
        wdata_q <= wdata_lane;
        word_q  <= req_word;
        a0_q    <= req_addr[0];
      end
      if (capture) begin
        rdata_q <= rd_aligned;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_rd_n  = ~act_q.rd;
  assign mem_wrh_n = ~act_q.wrh;
  assign mem_wrl_n = ~act_q.wrl;
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/membus_lane_chk.sv
module membus_lane_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_a0,
  input logic req_write,
  input logic req_word,
  input logic mem_rd_n,
  input logic mem_wrh_n,
  input logic mem_wrl_n,
  input logic rsp_done,
  input logic rsp_err
);
  logic any_strobe;
  assign any_strobe = ~mem_rd_n | ~mem_wrh_n | ~mem_wrl_n;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    any_strobe |=> !any_strobe); // R2

  AST_EVEN_BYTE_HIGH_LANE: assert property (@(posedge clk) disable iff (rst)
    (!mem_wrh_n && mem_wrl_n) |-> $past(req_write && !req_word && !req_a0)); // R3

  AST_ODD_BYTE_LOW_LANE: assert property (@(posedge clk) disable iff (rst)
    (mem_wrh_n && !mem_wrl_n) |-> $past(req_write && !req_word && req_a0)); // R4

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (rst)
    (!mem_wrh_n && !mem_wrl_n) |-> $past(req_write && req_word && !req_a0)); // R5

  AST_READ_ALONE: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (mem_wrh_n && mem_wrl_n)); // R6

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    any_strobe |=> rsp_done); // R8

  AST_DONE_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(any_strobe)); // R8

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!any_strobe && !rsp_done)); // R9

  AST_ERR_FROM_MISALIGN: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid && req_word && req_a0)); // R9
endmodule

bind membus_lane_ctrl membus_lane_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_a0    (req_addr[0]),
  .req_write (req_write),
  .req_word  (req_word),
  .mem_rd_n  (mem_rd_n),
  .mem_wrh_n (mem_wrh_n),
  .mem_wrl_n (mem_wrl_n),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err)
);

// File: tb/test_membus_lane_ctrl.sv
`timescale 1ns/1ps
module test_membus_lane_ctrl;
  localparam int ADDR_W = 24;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              req_word = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [ADDR_W-2:0] mem_addr;
  logic              mem_rd_n, mem_wrh_n, mem_wrl_n;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              rsp_done, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  membus_lane_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_membus_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wrh_n(mem_wrh_n),
    .mem_wrl_n(mem_wrl_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected {rd_n, wrh_n, wrl_n}
  function automatic logic [2:0] exp_strobes(input logic wr, input logic wd, input logic a0);
    if (!wr) return 3'b011;
    if (wd) return 3'b100;
    return a0 ? 3'b110 : 3'b101;
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(input logic wd, input logic a0, input logic [DATA_W-1:0] bus);
    if (wd) return bus;
    return a0 ? {8'h00, bus[7:0]} : {8'h00, bus[15:8]};
  endfunction

  // starts and ends at a falling edge
  task automatic do_req(input logic [ADDR_W-1:0] a, input logic wr, input logic wd,
                        input logic [DATA_W-1:0] wdat, input logic [DATA_W-1:0] bus,
                        input bit overlap);
    logic [2:0] st;
    logic [DATA_W-1:0] prev_rd;
    prev_rd   = rsp_rdata;
    req_valid = 1'b1; req_addr = a; req_write = wr; req_word = wd; req_wdata = wdat;
    @(negedge clk);
    if (wd && a[0]) begin
      req_valid = 1'b0;
      chk(rsp_err === 1'b1, "R9 err pulse", {31'b0, rsp_err}, 32'd1);
      chk({mem_rd_n, mem_wrh_n, mem_wrl_n} === 3'b111 && rsp_done === 1'b0,
          "R9 no strobe", {28'b0, rsp_done, mem_rd_n, mem_wrh_n, mem_wrl_n}, 32'h7);
      @(negedge clk);
      chk(rsp_err === 1'b0 && rsp_done === 1'b0, "R9 single pulse",
          {30'b0, rsp_err, rsp_done}, 32'd0);
      chk(rsp_rdata === prev_rd, "R9 rdata kept", {16'b0, rsp_rdata}, {16'b0, prev_rd});
      return;
    end
    st = exp_strobes(wr, wd, a[0]);
    chk({mem_rd_n, mem_wrh_n, mem_wrl_n} === st, wr ? (wd ? "R5 strobes" : (a[0] ? "R4 strobes" : "R3 strobes")) : "R6 strobes",
        {29'b0, mem_rd_n, mem_wrh_n, mem_wrl_n}, {29'b0, st});
    chk(mem_addr === a[ADDR_W-1:1], "R2 mem_addr", {9'b0, mem_addr}, {9'b0, a[ADDR_W-1:1]});
    if (wr && wd)
      chk(mem_wdata === wdat, "R5 wdata", {16'b0, mem_wdata}, {16'b0, wdat});
    else if (wr && !a[0])
      chk(mem_wdata[15:8] === wdat[7:0], "R3 lane data", {24'b0, mem_wdata[15:8]}, {24'b0, wdat[7:0]});
    else if (wr)
      chk(mem_wdata[7:0] === wdat[7:0], "R4 lane data", {24'b0, mem_wdata[7:0]}, {24'b0, wdat[7:0]});
    mem_rdata = bus;
    if (overlap) begin
      req_addr = ~a; req_write = ~wr; req_word = 1'b0;
    end else begin
      req_valid = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({mem_rd_n, mem_wrh_n, mem_wrl_n} === 3'b111, overlap ? "R10 ignored strobes" : "R2 one cycle",
        {29'b0, mem_rd_n, mem_wrh_n, mem_wrl_n}, 32'h7);
    if (overlap)
      chk(mem_addr === a[ADDR_W-1:1], "R10 addr kept", {9'b0, mem_addr}, {9'b0, a[ADDR_W-1:1]});
    chk(rsp_done === 1'b1 && rsp_err === 1'b0, "R8 done", {30'b0, rsp_done, rsp_err}, 32'd2);
    if (!wr)
      chk(rsp_rdata === exp_read(wd, a[0], bus), wd ? "R6 word read" : "R7 byte read",
          {16'b0, rsp_rdata}, {16'b0, exp_read(wd, a[0], bus)});
    else
      chk(rsp_rdata === prev_rd, "R8 rdata kept on write", {16'b0, rsp_rdata}, {16'b0, prev_rd});
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    chk({mem_rd_n, mem_wrh_n, mem_wrl_n} === 3'b111 && rsp_done === 1'b0 && rsp_err === 1'b0,
        "R1 reset outputs", {27'b0, rsp_done, rsp_err, mem_rd_n, mem_wrh_n, mem_wrl_n}, 32'h7);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_rdata === '0 && rsp_done === 1'b0, "R1 idle after reset", {16'b0, rsp_rdata}, 32'd0);

    // directed corners
    do_req(24'h100000, 1'b1, 1'b0, 16'h00A5, 16'h0, 1'b0); // R3
    do_req(24'h100001, 1'b1, 1'b0, 16'h005A, 16'h0, 1'b0); // R4
    do_req(24'h100002, 1'b1, 1'b1, 16'hBEEF, 16'h0, 1'b0); // R5
    do_req(24'h100004, 1'b0, 1'b1, 16'h0,    16'h1234, 1'b0); // R6
    do_req(24'h100006, 1'b0, 1'b0, 16'h0,    16'hABCD, 1'b0); // R7 even
    do_req(24'h100007, 1'b0, 1'b0, 16'h0,    16'hABCD, 1'b0); // R7 odd
    do_req(24'h100003, 1'b1, 1'b1, 16'hFFFF, 16'h0, 1'b0); // R9 write
    do_req(24'h1FFFFF, 1'b0, 1'b1, 16'h0,    16'h0, 1'b0); // R9 read
    do_req(24'h000010, 1'b0, 1'b0, 16'h0,    16'hC3E1, 1'b1); // R10
    do_req(24'hFFFFFE, 1'b1, 1'b1, 16'h0102, 16'h0, 1'b1); // R10

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic wr, wd;
      a  = ADDR_W'($urandom);
      wr = 1'($urandom);
      wd = 1'($urandom);
      if (wd && ($urandom % 4) != 0) a[0] = 1'b0;
      do_req(a, wr, wd, 16'($urandom), 16'($urandom), ($urandom % 8) == 0);
      if (($urandom % 3) == 0) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule